// File: doc/BRIEF.md
# Banked DMA Channel Register File

This block is the software-facing register front end of a multi-channel DMA engine. The engine copies blocks between on-chip tightly coupled memory and external memory. Each channel keeps its own bank of setup registers: a control word, a context ID, the internal start and end addresses of the on-chip range, and the external start address. Software reaches these banks indirectly. It first writes a channel-select register and then accesses the banked registers, which always refer to the selected channel.

Three write-only command registers start, stop or clear the selected channel. A small scheduler inside the block tracks the state of every channel. Each channel is in one of four states: `CH_IDLE`, `CH_QUEUED`, `CH_RUNNING` or `CH_INTR` (interrupting). The legal transitions are:
- start: `CH_IDLE` to `CH_RUNNING`, or to `CH_QUEUED` when the engine is busy;
- completion: `CH_RUNNING` to `CH_INTR`;
- promotion: `CH_QUEUED` to `CH_RUNNING`;
- stop: any state to `CH_IDLE`;
- clear: `CH_INTR` to `CH_IDLE`.

At most one channel runs at a time. Queued channels are promoted in the order in which they were started. The transfer datapath is external. It receives the running channel on `run_chan`/`run_valid` and reports completion on `xfer_done`.

Accesses made in user mode (`acc_user`=1) are filtered by a permission register. A forbidden access does not complete. Instead it raises `acc_trap`, which the core turns into an undefined-instruction exception.

Top module: `dma_chan_regs`

Register select codes on `acc_sel` (all registers are 32 bits wide):

| Code | Register | Access | Permission class in user mode |
|------|----------|--------|-------------------------------|
| 0 | IDENT | read-only | always allowed |
| 1 | PRESENT | read-only | always allowed |
| 2 | USERACC | read/write | read allowed, write always traps |
| 3 | CHSEL | read/write | setup |
| 4 | START | write-only | command |
| 5 | STOP | write-only | command |
| 6 | CLEAR | write-only | command |
| 7 | CTRL (banked) | read/write | setup |
| 8 | INT_START (banked) | read/write | setup |
| 9 | EXT_START (banked) | read/write | setup |
| 10 | INT_END (banked) | read/write | setup |
| 11 | STATUS (banked) | read-only | status |
| 12 | CTX (banked) | read/write | setup |
| 13 | ACTIVE | read-only | status |
| 14 | IRQ_PEND | read-only | status |

Register contents:
- IDENT reads NUM_CH.
- PRESENT reads one bit per implemented channel.
- STATUS: bit0 queued, bit1 running, bit2 interrupting.
- ACTIVE: bits [7:0] hold the running channel and bit 8 is set while a channel runs.
- IRQ_PEND: one bit per channel in `CH_INTR`.

## Requirements
- R1: After reset:
  - every channel is `CH_IDLE` and every banked register is 0;
  - CHSEL and USERACC read 0;
  - `run_valid`, `irq` and `acc_trap` are 0.
- R2: An allowed write to a banked register (codes 7, 8, 9, 10, 12) changes only the copy belonging to the channel in CHSEL. A read of that code returns the selected channel's copy.
- R3: A CHSEL write with a value greater than or equal to NUM_CH leaves the selection unchanged.
- R4: START on an idle channel, while no channel is running or queued, makes it `CH_RUNNING` (STATUS = 2). `run_valid` becomes 1 and `run_chan` shows that channel. At most one channel is ever running.
- R5: START on an idle channel while another channel is running makes it `CH_QUEUED` (STATUS = 1).
- R6: A `xfer_done` pulse while a channel runs moves that channel to `CH_INTR` (STATUS = 4) and raises `irq`.
- R7: When the running channel leaves `CH_RUNNING`, the queued channel that was started earliest becomes `CH_RUNNING` in the same cycle.
- R8: STOP returns the selected channel to `CH_IDLE` from any state. Stopping the running channel promotes the next queued channel.
- R9: CLEAR moves an interrupting channel to `CH_IDLE`. CLEAR on a channel in any other state has no effect.
- R10: In user mode, each class of access needs its USERACC bit:
  - setup (CHSEL write and banked read/write registers) needs bit0;
  - command (START, STOP, CLEAR) needs bit1;
  - status reads (codes 11, 13, 14) need bit2.

  A denied access changes nothing, raises `acc_trap`, and returns read data 0.
- R11: A user-mode write to USERACC always traps and leaves USERACC unchanged.
- R12: IDENT reads NUM_CH and PRESENT reads a mask of NUM_CH ones. Writes to read-only codes are ignored, and reads of write-only codes return 0.
- R13: `acc_rdata` and `acc_trap` are registered. They are valid in the cycle after the access, and are 0 in cycles that follow no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | Access made from unprivileged mode |
| acc_sel | input | 4 | Register select code |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the access |
| acc_trap | output | 1 | Undefined-instruction trap, one cycle after a denied access |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| run_valid | output | 1 | A channel is running |
| run_chan | output | CH_W | Index of the running channel |
| irq | output | 1 | Some channel is interrupting |

## Verification
A corrupted channel state shows within one access: the next STATUS or ACTIVE read returns a wrong code. `run_valid`/`run_chan` also go wrong in the cycle right after the faulty edge. Errors in the age ordering of queued channels stay hidden until a promotion. At that point `run_chan` names the wrong channel in the cycle after the completion or stop. For this reason the bench queues several channels, in an order that differs from their index order. A wrong permission decode shows at once on `acc_trap`. It also shows as a changed or unchanged register on the next privileged read-back.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_QUEUED,
        CH_RUNNING,
        CH_INTR
    } ch_state_e;

    typedef enum logic [3:0] {
        REG_IDENT     = 4'd0,
        REG_PRESENT   = 4'd1,
        REG_USERACC   = 4'd2,
        REG_CHSEL     = 4'd3,
        REG_START     = 4'd4,
        REG_STOP      = 4'd5,
        REG_CLEAR     = 4'd6,
        REG_CTRL      = 4'd7,
        REG_INT_START = 4'd8,
        REG_EXT_START = 4'd9,
        REG_INT_END   = 4'd10,
        REG_STATUS    = 4'd11,
        REG_CTX       = 4'd12,
        REG_ACTIVE    = 4'd13,
        REG_IRQ_PEND  = 4'd14,
        REG_NONE      = 4'd15
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_START,
        CMD_STOP,
        CMD_CLEAR
    } cmd_e;

    localparam int UA_SETUP = 0;
    localparam int UA_CMD   = 1;
    localparam int UA_STAT  = 2;
    localparam int UA_W     = 3;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] int_start;
        logic [31:0] ext_start;
        logic [31:0] int_end;
        logic [31:0] ctx;
    } bank_t;

endpackage

// File: rtl/dma_access_ctrl.sv
module dma_access_ctrl
    import dma_chan_pkg::*;
(
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic            acc_user,
    input  reg_sel_e        sel,
    input  logic [UA_W-1:0] ua,
    output logic            trap,
    output logic            wr_ok,
    output logic            rd_ok,
    output cmd_e            cmd
);
    logic is_setup, is_cmd, is_stat, is_uaw, deny, ok;

    always_comb begin
        is_setup = 1'b0;
        is_cmd   = 1'b0;
        is_stat  = 1'b0;
        is_uaw   = 1'b0;
        unique case (sel)
            REG_CHSEL, REG_CTRL, REG_INT_START, REG_EXT_START,
            REG_INT_END, REG_CTX:                   is_setup = 1'b1;
            REG_START, REG_STOP, REG_CLEAR:         is_cmd   = acc_write;
            REG_STATUS, REG_ACTIVE, REG_IRQ_PEND:   is_stat  = !acc_write;
            REG_USERACC:                            is_uaw   = acc_write;
            default: ;
        endcase
        deny = acc_user && ((is_setup && !ua[UA_SETUP]) ||
                            (is_cmd   && !ua[UA_CMD])   ||
                            (is_stat  && !ua[UA_STAT])  ||
                            is_uaw);
        ok    = acc_valid && !deny;
        trap  = acc_valid && deny;
        wr_ok = ok && acc_write;
        rd_ok = ok && !acc_write;
        cmd   = CMD_NONE;
        if (wr_ok) begin
            unique case (sel)
                REG_START: cmd = CMD_START;
                REG_STOP:  cmd = CMD_STOP;
                REG_CLEAR: cmd = CMD_CLEAR;
                default:   cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dma_chan_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ok,
    input  reg_sel_e        sel,
    input  logic [31:0]     wdata,
    input  logic [CH_W-1:0] ch,
    output bank_t           rd_bank
);
    bank_t bank_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_ok && ch == CH_W'(g)) begin
                unique case (sel)
                    REG_CTRL:      bank_q[g].ctrl      <= wdata;
                    REG_INT_START: bank_q[g].int_start <= wdata;
                    REG_EXT_START: bank_q[g].ext_start <= wdata;
                    REG_INT_END:   bank_q[g].int_end   <= wdata;
                    REG_CTX:       bank_q[g].ctx       <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign rd_bank = bank_q[ch];
endmodule

// File: rtl/dma_sched.sv
module dma_sched
    import dma_chan_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [CH_W-1:0]   ch,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] run_mask,
    output logic [NUM_CH-1:0] queued_mask,
    output logic [NUM_CH-1:0] intr_mask,
    output logic              run_valid,
    output logic [CH_W-1:0]   run_chan
);
    ch_state_e         st_q [NUM_CH];
    ch_state_e         st_d [NUM_CH];
    // older_q[i][j] set: channel i entered the queue before channel j
    logic [NUM_CH-1:0] older_q [NUM_CH];
    logic [NUM_CH-1:0] older_d [NUM_CH];

    always_comb begin
        logic busy, has_run, promoted, blocked;
        st_d    = st_q;
        older_d = older_q;
        // completion first: the running channel becomes interrupting
        if (xfer_done) begin
            for (int i = 0; i < NUM_CH; i++)
                if (st_d[i] == CH_RUNNING) st_d[i] = CH_INTR;
        end
        busy = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (st_d[i] == CH_RUNNING || st_d[i] == CH_QUEUED) busy = 1'b1;
        unique case (cmd)
            CMD_START: begin
                if (st_d[ch] == CH_IDLE) begin
                    if (busy) begin
                        st_d[ch] = CH_QUEUED;
                        for (int j = 0; j < NUM_CH; j++) older_d[j][ch] = 1'b1;
                        older_d[ch] = '0;
                    end else begin
                        st_d[ch] = CH_RUNNING;
                    end
                end
            end
            CMD_STOP:  st_d[ch] = CH_IDLE;
            CMD_CLEAR: if (st_d[ch] == CH_INTR) st_d[ch] = CH_IDLE;
            default: ;
        endcase
        // promotion of the oldest queued channel
        has_run = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (st_d[i] == CH_RUNNING) has_run = 1'b1;
        promoted = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            blocked = 1'b0;
            for (int j = 0; j < NUM_CH; j++)
                if (st_d[j] == CH_QUEUED && older_d[j][i]) blocked = 1'b1;
            if (!has_run && !promoted && st_d[i] == CH_QUEUED && !blocked) begin
                st_d[i]  = CH_RUNNING;
                promoted = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n) begin
                st_q[i]    <= CH_IDLE;
                older_q[i] <= '0;
            end else begin
                st_q[i]    <= st_d[i];
                older_q[i] <= older_d[i];
            end
        end
    end

    always_comb begin
        run_valid = 1'b0;
        run_chan  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            run_mask[i]    = (st_q[i] == CH_RUNNING);
            queued_mask[i] = (st_q[i] == CH_QUEUED);
            intr_mask[i]   = (st_q[i] == CH_INTR);
            if (st_q[i] == CH_RUNNING) begin
                run_valid = 1'b1;
                run_chan  = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic            acc_user,
    input  logic [3:0]      acc_sel,
    input  logic [31:0]     acc_wdata,
    output logic [31:0]     acc_rdata,
    output logic            acc_trap,
    input  logic            xfer_done,
    output logic            run_valid,
    output logic [CH_W-1:0] run_chan,
    output logic            irq
);
    reg_sel_e          sel;
    logic [CH_W-1:0]   sel_q;
    logic [UA_W-1:0]   ua_q;
    logic              trap, wr_ok, rd_ok;
    cmd_e              cmd;
    bank_t             rd_bank;
    logic [NUM_CH-1:0] run_mask, queued_mask, intr_mask;
    logic [31:0]       rd_val;

    assign sel = reg_sel_e'(acc_sel);

    dma_access_ctrl u_acc (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_user  (acc_user),
        .sel       (sel),
        .ua        (ua_q),
        .trap      (trap),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .cmd       (cmd)
    );

    dma_chan_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .sel     (sel),
        .wdata   (acc_wdata),
        .ch      (sel_q),
        .rd_bank (rd_bank)
    );

    dma_sched #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .ch          (sel_q),
        .xfer_done   (xfer_done),
        .run_mask    (run_mask),
        .queued_mask (queued_mask),
        .intr_mask   (intr_mask),
        .run_valid   (run_valid),
        .run_chan    (run_chan)
    );

    // global registers: selection and user permissions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ua_q  <= '0;
        end else if (wr_ok) begin
            if (sel == REG_CHSEL && acc_wdata < 32'(NUM_CH))
                sel_q <= acc_wdata[CH_W-1:0];
            if (sel == REG_USERACC)
                ua_q <= acc_wdata[UA_W-1:0];
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (sel)
            REG_IDENT:     rd_val = 32'(NUM_CH);
            REG_PRESENT:   rd_val = 32'({NUM_CH{1'b1}});
            REG_USERACC:   rd_val = 32'(ua_q);
            REG_CHSEL:     rd_val = 32'(sel_q);
            REG_CTRL:      rd_val = rd_bank.ctrl;
            REG_INT_START: rd_val = rd_bank.int_start;
            REG_EXT_START: rd_val = rd_bank.ext_start;
            REG_INT_END:   rd_val = rd_bank.int_end;
            REG_CTX:       rd_val = rd_bank.ctx;
            REG_STATUS:    rd_val = {29'd0, intr_mask[sel_q], run_mask[sel_q],
                                     queued_mask[sel_q]};
            REG_ACTIVE: begin
                rd_val    = 32'(run_chan);
                rd_val[8] = run_valid;
            end
            REG_IRQ_PEND:  rd_val = 32'(intr_mask);
            default:       rd_val = '0;
        endcase
    end

    // registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata <= '0;
            acc_trap  <= 1'b0;
        end else begin
            acc_rdata <= rd_ok ? rd_val : '0;
            acc_trap  <= trap;
        end
    end

    assign irq = |intr_mask;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_user,
    input logic [3:0]        acc_sel,
    input logic [31:0]       acc_rdata,
    input logic              acc_trap,
    input logic              xfer_done,
    input logic              run_valid,
    input logic [CH_W-1:0]   run_chan,
    input logic              irq,
    input logic [NUM_CH-1:0] run_mask,
    input logic [NUM_CH-1:0] queued_mask,
    input logic [CH_W-1:0]   sel_q
);
    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel_q) < NUM_CH);                                                // R3
    AST_ONE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(run_mask));                                                 // R4
    AST_QUEUE_NEEDS_RUNNER: assert property (@(posedge clk) disable iff (!rst_n)
        (|queued_mask) |-> (|run_mask));                                     // R5
    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && run_valid && !acc_valid) |=> irq);                     // R6
    AST_RUN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !xfer_done) |=> ($stable(run_valid) && $stable(run_chan))); // R8
    AST_TRAP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_trap |-> $past(acc_valid));                                      // R10
    AST_USERACC_WRITE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_user && acc_sel == 4'd2) |=> acc_trap); // R11
    AST_DATA_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rdata != 32'd0) |-> $past(acc_valid));                          // R13
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_user    (acc_user),
    .acc_sel     (acc_sel),
    .acc_rdata   (acc_rdata),
    .acc_trap    (acc_trap),
    .xfer_done   (xfer_done),
    .run_valid   (run_valid),
    .run_chan    (run_chan),
    .irq         (irq),
    .run_mask    (run_mask),
    .queued_mask (queued_mask),
    .sel_q       (sel_q)
);

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
    localparam int NCH = 3;
    localparam int CW  = 2;

    localparam logic [3:0] S_IDENT = 4'd0, S_PRESENT = 4'd1, S_UA = 4'd2,
        S_CHSEL = 4'd3, S_START = 4'd4, S_STOP = 4'd5, S_CLEAR = 4'd6,
        S_CTRL = 4'd7, S_ISTART = 4'd8, S_ESTART = 4'd9, S_IEND = 4'd10,
        S_STATUS = 4'd11, S_CTX = 4'd12, S_ACTIVE = 4'd13, S_IRQP = 4'd14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_user = 1'b0;
    logic [3:0]  acc_sel = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_trap;
    logic        xfer_done = 1'b0;
    logic        run_valid;
    logic [CW-1:0] run_chan;
    logic        irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        trap;
        string       tag;
    } exp_t;
    exp_t exp_q [$];

    always #5 clk = ~clk;

    dma_chan_regs #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_user(acc_user), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_trap(acc_trap), .xfer_done(xfer_done),
        .run_valid(run_valid), .run_chan(run_chan), .irq(irq)
    );

    // monitor: compares each response against the scoreboard queue
    always @(posedge clk) begin
        if (acc_valid) begin
            #2;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R13: response with no expectation, rdata=%h", acc_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (acc_rdata !== e.rdata || acc_trap !== e.trap) begin
                    errors++;
                    $display("FAIL %s: rdata=%h trap=%b expected rdata=%h trap=%b",
                             e.tag, acc_rdata, acc_trap, e.rdata, e.trap);
                end
            end
        end
    end

    // driver: one access, expectation pushed to the scoreboard
    task automatic acc(input logic wr, input logic usr, input logic [3:0] sel,
                       input logic [31:0] wd, input logic [31:0] er,
                       input logic et, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_user = usr;
        acc_sel = sel; acc_wdata = wd;
        exp_q.push_back('{rdata: er, trap: et, tag: tag});
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_user = 1'b0;
    endtask

    task automatic wr_p(input logic [3:0] sel, input logic [31:0] wd, input string tag);
        acc(1'b1, 1'b0, sel, wd, 32'd0, 1'b0, tag);
    endtask

    task automatic rd_p(input logic [3:0] sel, input logic [31:0] er, input string tag);
        acc(1'b0, 1'b0, sel, 32'd0, er, 1'b0, tag);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(32'(run_valid), 0, "R1 run_valid");
        chk(32'(irq), 0, "R1 irq");
        chk(32'(acc_trap), 0, "R1 trap");
        rd_p(S_CHSEL, 0, "R1 chsel");
        rd_p(S_UA, 0, "R1 useracc");
        rd_p(S_CTRL, 0, "R1 ctrl");
        rd_p(S_STATUS, 0, "R1 status");
        // R12 read-only / write-only
        rd_p(S_IDENT, NCH, "R12 ident");
        rd_p(S_PRESENT, 32'h7, "R12 present");
        wr_p(S_IDENT, 32'h55, "R12 ident write");
        rd_p(S_IDENT, NCH, "R12 ident unchanged");
        rd_p(S_START, 0, "R12 start reads 0");
        // R2 banked registers
        wr_p(S_CHSEL, 1, "R2 sel1");
        wr_p(S_ISTART, 32'h1000, "R2 wr istart");
        wr_p(S_ESTART, 32'h8000_0000, "R2 wr estart");
        wr_p(S_IEND, 32'h1FFF, "R2 wr iend");
        wr_p(S_CTX, 32'hAB, "R2 wr ctx");
        wr_p(S_CTRL, 32'h11, "R2 wr ctrl");
        rd_p(S_ISTART, 32'h1000, "R2 istart ch1");
        rd_p(S_ESTART, 32'h8000_0000, "R2 estart ch1");
        rd_p(S_IEND, 32'h1FFF, "R2 iend ch1");
        rd_p(S_CTX, 32'hAB, "R2 ctx ch1");
        rd_p(S_CTRL, 32'h11, "R2 ctrl ch1");
        wr_p(S_CHSEL, 0, "R2 sel0");
        rd_p(S_ISTART, 0, "R2 ch0 untouched");
        wr_p(S_ISTART, 32'h2000, "R2 wr ch0");
        rd_p(S_ISTART, 32'h2000, "R2 istart ch0");
        wr_p(S_CHSEL, 1, "R2 sel1 again");
        rd_p(S_ISTART, 32'h1000, "R2 ch1 kept");
        // R3 out-of-range selection
        wr_p(S_CHSEL, 3, "R3 sel3");
        rd_p(S_CHSEL, 1, "R3 sel kept after 3");
        wr_p(S_CHSEL, 32'h100, "R3 sel big");
        rd_p(S_CHSEL, 1, "R3 sel kept after big");
        // R4 start with nothing busy
        wr_p(S_START, 0, "R4 start ch1");
        rd_p(S_STATUS, 2, "R4 ch1 running");
        chk(32'(run_valid), 1, "R4 run_valid");
        chk(32'(run_chan), 1, "R4 run_chan");
        // R5 start while busy: ch2 then ch0
        wr_p(S_CHSEL, 2, "R5 sel2");
        wr_p(S_START, 0, "R5 start ch2");
        rd_p(S_STATUS, 1, "R5 ch2 queued");
        wr_p(S_CHSEL, 0, "R5 sel0");
        wr_p(S_START, 0, "R5 start ch0");
        rd_p(S_STATUS, 1, "R5 ch0 queued");
        rd_p(S_ACTIVE, 32'h101, "R5 active ch1");
        // R6 / R7 completion
        done_pulse();
        chk(32'(run_chan), 2, "R7 oldest queued runs");
        chk(32'(irq), 1, "R6 irq");
        wr_p(S_CHSEL, 1, "R6 sel1");
        rd_p(S_STATUS, 4, "R6 ch1 interrupting");
        rd_p(S_IRQP, 32'h2, "R6 irq pend");
        // R9 clear
        wr_p(S_CHSEL, 2, "R9 sel2");
        wr_p(S_CLEAR, 0, "R9 clear running");
        rd_p(S_STATUS, 2, "R9 running unaffected");
        wr_p(S_CHSEL, 1, "R9 sel1");
        wr_p(S_CLEAR, 0, "R9 clear intr");
        rd_p(S_STATUS, 0, "R9 ch1 idle");
        chk(32'(irq), 0, "R9 irq low");
        // R8 stop running promotes next
        wr_p(S_CHSEL, 2, "R8 sel2");
        wr_p(S_STOP, 0, "R8 stop ch2");
        rd_p(S_STATUS, 0, "R8 ch2 idle");
        chk(32'(run_chan), 0, "R8 ch0 promoted");
        chk(32'(run_valid), 1, "R8 run_valid");
        done_pulse();
        chk(32'(run_valid), 0, "R6 none running");
        wr_p(S_CHSEL, 0, "R9 sel0");
        wr_p(S_CLEAR, 0, "R9 clear ch0");
        rd_p(S_STATUS, 0, "R9 ch0 idle");
        // R10 user permissions, all denied
        acc(1'b1, 1'b1, S_CTRL, 32'h55, 0, 1'b1, "R10 user ctrl denied");
        rd_p(S_CTRL, 0, "R10 ctrl unchanged");
        acc(1'b0, 1'b1, S_STATUS, 0, 0, 1'b1, "R10 user status denied");
        acc(1'b1, 1'b1, S_START, 0, 0, 1'b1, "R10 user start denied");
        chk(32'(run_valid), 0, "R10 start had no effect");
        acc(1'b0, 1'b1, S_IDENT, 0, NCH, 1'b0, "R10 user ident allowed");
        // R10 user permissions, all granted
        wr_p(S_UA, 7, "R10 grant");
        acc(1'b1, 1'b1, S_START, 0, 0, 1'b0, "R10 user start ok");
        chk(32'(run_valid), 1, "R10 start took effect");
        acc(1'b0, 1'b1, S_STATUS, 0, 2, 1'b0, "R10 user status ok");
        acc(1'b1, 1'b1, S_CTRL, 32'h66, 0, 1'b0, "R10 user ctrl ok");
        rd_p(S_CTRL, 32'h66, "R10 ctrl written");
        // R11 user write to permissions
        acc(1'b1, 1'b1, S_UA, 0, 0, 1'b1, "R11 user useracc write traps");
        rd_p(S_UA, 7, "R11 useracc unchanged");
        // R13 idle cycle returns zero
        @(negedge clk);
        chk(acc_rdata, 0, "R13 idle rdata");
        chk(32'(acc_trap), 0, "R13 idle trap");
        repeat (3) @(negedge clk);
        chk(32'(exp_q.size()), 0, "R13 scoreboard drained");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule